// File: doc/BRIEF.md
# Hardware Lock Manager

This block is a central arbiter for mutual-exclusion locks shared by a cluster of cores. A core asks for a lock, or gives one up, by presenting a one-cycle request that carries its core number, a lock number and an opcode. No memory is read or written on the way. The manager keeps, for every lock, whether it is taken, which core holds it, and an ordered list of the cores still waiting for it.

An acknowledge goes out only at the moment a core becomes the holder. A core that asks for a taken lock therefore just waits for its acknowledge and never polls. When the holder lets go, the lock passes straight to the oldest waiter, and that core receives its acknowledge. Two misuse cases raise a one-cycle flag and change nothing:
- a release from a core that does not hold the lock;
- a second acquire from the core that already holds it, which would otherwise leave that core waiting on itself.

Each lock runs a two-state machine:
- FREE goes to HELD on an acquire (transition GRANT_IDLE).
- HELD stays HELD on an acquire from another core (ENQUEUE).
- HELD stays HELD on the holder's release while waiters exist (HANDOFF).
- HELD goes to FREE on the holder's release with no waiters (VACATE).
- Every other request is a fault transition (BAD_RELEASE or SELF_DEADLOCK) that leaves the state as it was.

Top module: `smgr_lock_mgr`

## Requirements
- R1: After reset every lock is FREE and no acknowledge or fault flag is raised.
- R2: An acquire (req_op = 0) on a FREE lock makes the requester the holder, and the cycle after the request it raises grant_valid with grant_core and grant_lock equal to the requester and the lock.
- R3: An acquire on a HELD lock from a core other than the holder raises no acknowledge and adds the core to the end of that lock's wait list.
- R4: A release (req_op = 1) by the holder of a lock that has waiters makes the oldest waiter the new holder. The cycle after the release, an acknowledge to that core is raised for that lock, so waiters are served in arrival order.
- R5: A release by the holder of a lock with no waiters returns it to FREE with no acknowledge, and the next acquire of it is granted at once.
- R6: A release from a core that is not the holder, or a release of a FREE lock, raises bad_release for one cycle the next cycle and leaves holder and wait list unchanged.
- R7: An acquire from the current holder raises self_deadlock for one cycle the next cycle, raises no acknowledge, and does not put the core on the wait list.
- R8: Locks are independent: a request on one lock never changes the holder, the wait list or the acknowledges of another.
- R9: At most one of grant_valid, bad_release and self_deadlock is high in a cycle, and each appears only in the cycle after an accepted request. A cycle with req_valid low produces none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_core | input | CORE_W | Requesting core number |
| req_lock | input | LOCK_W | Lock number addressed |
| req_op | input | 1 | 0 = acquire, 1 = release |
| grant_valid | output | 1 | Acknowledge: a core has become holder |
| grant_core | output | CORE_W | Core receiving the acknowledge |
| grant_lock | output | LOCK_W | Lock that was granted |
| bad_release | output | 1 | Release by a core that was not the holder |
| self_deadlock | output | 1 | Acquire by the core that already holds the lock |

## Verification
The hardest case to reach is a lock whose wait list is full, with every other core waiting. Here the oldest-first order must survive a long chain of handoffs while other locks are also in use. A directed sequence gives one lock to core 0, then queues all the remaining cores in order, and releases holder after holder so that each acknowledge has to name the next core in line. Seeded random traffic then follows. It is held to three locks so that contention stays high, it never sends from a core the model has marked as waiting, and it often picks the current holder so that handoffs, self-deadlock and bad releases all occur often.

// File: rtl/smgr_pkg.sv
package smgr_pkg;

    typedef enum logic {
        OP_ACQUIRE = 1'b0,
        OP_RELEASE = 1'b1
    } smgr_op_e;

    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lk_state_e;

endpackage

// File: rtl/smgr_waitq.sv
module smgr_waitq #(
    parameter int DEPTH = 16,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head  = slots[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push && !full)
                wr_ptr <= bump(wr_ptr);
            if (pop && !empty)
                rd_ptr <= bump(rd_ptr);
            unique case ({push && !full, pop && !empty})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full)
            slots[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/smgr_lock_unit.sv
module smgr_lock_unit
    import smgr_pkg::*;
#(
    parameter int NUM_CORES = 16,
    parameter int CORE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  smgr_op_e          op,
    input  logic [CORE_W-1:0] core,
    output logic              held,
    output logic [CORE_W-1:0] owner,
    output logic              fire,
    output logic [CORE_W-1:0] fire_core,
    output logic              bad_rel,
    output logic              self_dl
);
    lk_state_e         state, state_n;
    logic [CORE_W-1:0] owner_n;
    logic              q_push, q_pop, q_empty, q_full;
    logic [CORE_W-1:0] q_head;

    smgr_waitq #(.DEPTH(NUM_CORES), .W(CORE_W)) waitq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (core),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LK_FREE;
            owner <= '0;
        end else begin
            state <= state_n;
            owner <= owner_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n   = state;
        owner_n   = owner;
        fire      = 1'b0;
        fire_core = '0;
        bad_rel   = 1'b0;
        self_dl   = 1'b0;
        q_push    = 1'b0;
        q_pop     = 1'b0;
        if (hit) begin
            unique case (state)
                LK_FREE: begin
                    if (op == OP_ACQUIRE) begin      // GRANT_IDLE
                        state_n   = LK_HELD;
                        owner_n   = core;
                        fire      = 1'b1;
                        fire_core = core;
                    end else begin                   // BAD_RELEASE
                        bad_rel = 1'b1;
                    end
                end
                LK_HELD: begin
                    if (op == OP_ACQUIRE) begin
                        if (core == owner)
                            self_dl = 1'b1;          // SELF_DEADLOCK
                        else
                            q_push = !q_full;        // ENQUEUE
                    end else if (core != owner) begin
                        bad_rel = 1'b1;              // BAD_RELEASE
                    end else if (q_empty) begin
                        state_n = LK_FREE;           // VACATE
                    end else begin                   // HANDOFF
                        q_pop     = 1'b1;
                        owner_n   = q_head;
                        fire      = 1'b1;
                        fire_core = q_head;
                    end
                end
                default: state_n = LK_FREE;
            endcase
        end
    end

    assign held = (state == LK_HELD);

endmodule

// File: rtl/smgr_lock_mgr.sv
module smgr_lock_mgr
    import smgr_pkg::*;
#(
    parameter int NUM_CORES = 16,
    parameter int NUM_LOCKS = 8,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int LOCK_W   = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CORE_W-1:0] req_core,
    input  logic [LOCK_W-1:0] req_lock,
    input  logic              req_op,
    output logic              grant_valid,
    output logic [CORE_W-1:0] grant_core,
    output logic [LOCK_W-1:0] grant_lock,
    output logic              bad_release,
    output logic              self_deadlock
);
    logic [NUM_LOCKS-1:0]             hit_v, fire_v, bad_v, dl_v, held_vec;
    logic [NUM_LOCKS-1:0][CORE_W-1:0] fire_core_v, owner_vec;
    logic                             sel_fire, sel_bad, sel_dl;
    logic [CORE_W-1:0]                sel_core;

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
        assign hit_v[i] = req_valid && (req_lock == LOCK_W'(i));
        smgr_lock_unit #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) unit_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (hit_v[i]),
            .op        (smgr_op_e'(req_op)),
            .core      (req_core),
            .held      (held_vec[i]),
            .owner     (owner_vec[i]),
            .fire      (fire_v[i]),
            .fire_core (fire_core_v[i]),
            .bad_rel   (bad_v[i]),
            .self_dl   (dl_v[i])
        );
    end

    always_comb begin
        sel_fire = |fire_v;
        sel_bad  = |bad_v;
        sel_dl   = |dl_v;
        sel_core = '0;
        for (int i = 0; i < NUM_LOCKS; i++)
            if (fire_v[i]) sel_core = fire_core_v[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid   <= 1'b0;
            grant_core    <= '0;
            grant_lock    <= '0;
            bad_release   <= 1'b0;
            self_deadlock <= 1'b0;
        end else begin
            grant_valid   <= sel_fire;
            grant_core    <= sel_core;
            grant_lock    <= req_lock;
            bad_release   <= sel_bad;
            self_deadlock <= sel_dl;
        end
    end

endmodule

// File: rtl/smgr_lock_mgr_chk.sv
module smgr_lock_mgr_chk #(
    parameter int NUM_CORES = 16,
    parameter int NUM_LOCKS = 8,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int LOCK_W   = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             req_valid,
    input logic [CORE_W-1:0]                req_core,
    input logic [LOCK_W-1:0]                req_lock,
    input logic                             req_op,
    input logic                             grant_valid,
    input logic [CORE_W-1:0]                grant_core,
    input logic [LOCK_W-1:0]                grant_lock,
    input logic                             bad_release,
    input logic                             self_deadlock,
    input logic [NUM_LOCKS-1:0]             held_vec,
    input logic [NUM_LOCKS-1:0][CORE_W-1:0] owner_vec
);
    assert_free_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op && !held_vec[req_lock])
        |=> (grant_valid && grant_core == $past(req_core) && grant_lock == $past(req_lock)));

    assert_wait_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op && held_vec[req_lock] && owner_vec[req_lock] != req_core)
        |=> !grant_valid);

    assert_grant_is_holder_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (held_vec[grant_lock] && owner_vec[grant_lock] == grant_core));

    assert_bad_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op && (!held_vec[req_lock] || owner_vec[req_lock] != req_core))
        |=> (bad_release && !grant_valid));

    assert_self_deadlock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op && held_vec[req_lock] && owner_vec[req_lock] == req_core)
        |=> (self_deadlock && !grant_valid));

    assert_single_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_valid, bad_release, self_deadlock}));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(grant_valid || bad_release || self_deadlock));

endmodule

bind smgr_lock_mgr smgr_lock_mgr_chk #(.NUM_CORES(NUM_CORES), .NUM_LOCKS(NUM_LOCKS)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_core      (req_core),
    .req_lock      (req_lock),
    .req_op        (req_op),
    .grant_valid   (grant_valid),
    .grant_core    (grant_core),
    .grant_lock    (grant_lock),
    .bad_release   (bad_release),
    .self_deadlock (self_deadlock),
    .held_vec      (held_vec),
    .owner_vec     (owner_vec)
);

// File: tb/smgr_lock_mgr_tb.sv
module smgr_lock_mgr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 16;
    localparam int NL = 8;
    localparam int CW = 4;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [CW-1:0] req_core = '0;
    logic [LW-1:0] req_lock = '0;
    logic          req_op = 1'b0;
    logic          grant_valid, bad_release, self_deadlock;
    logic [CW-1:0] grant_core;
    logic [LW-1:0] grant_lock;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // independent reference model
    bit m_held [NL];
    int m_owner [NL];
    int m_q [NL][NC];
    int m_cnt [NL];
    bit m_wait [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    smgr_lock_mgr #(.NUM_CORES(NC), .NUM_LOCKS(NL)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_core      (req_core),
        .req_lock      (req_lock),
        .req_op        (req_op),
        .grant_valid   (grant_valid),
        .grant_core    (grant_core),
        .grant_lock    (grant_lock),
        .bad_release   (bad_release),
        .self_deadlock (self_deadlock)
    );

    task automatic check_out(input string tag, input bit eg, input int ec, input int el,
                             input bit ee, input bit ed);
        bit ok;
        n_checks++;
        ok = (grant_valid == eg) && (bad_release == ee) && (self_deadlock == ed);
        if (eg) ok = ok && (int'(grant_core) == ec) && (int'(grant_lock) == el);
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: grant=%0b core=%0d lock=%0d bad=%0b dl=%0b expected grant=%0b core=%0d lock=%0d bad=%0b dl=%0b",
                     tag, grant_valid, grant_core, grant_lock, bad_release, self_deadlock,
                     eg, ec, el, ee, ed);
        end
    endtask

    task automatic issue(input bit v, input int c, input int l, input bit op);
        string tag;
        bit eg = 0, ee = 0, ed = 0;
        int ec = 0;
        if (!v)                         tag = "R9";
        else if (!op) begin
            if (!m_held[l]) begin
                m_held[l] = 1; m_owner[l] = c; eg = 1; ec = c; tag = "R2";
            end else if (m_owner[l] == c) begin
                ed = 1; tag = "R7";
            end else begin
                m_q[l][m_cnt[l]] = c; m_cnt[l]++; m_wait[c] = 1; tag = "R3";
            end
        end else if (!m_held[l] || m_owner[l] != c) begin
            ee = 1; tag = "R6";
        end else if (m_cnt[l] == 0) begin
            m_held[l] = 0; tag = "R5";
        end else begin
            eg = 1; ec = m_q[l][0];
            for (int k = 0; k < NC - 1; k++) m_q[l][k] = m_q[l][k+1];
            m_cnt[l]--; m_owner[l] = ec; m_wait[ec] = 0; tag = "R4";
        end
        @(negedge clk);
        req_valid = v; req_core = CW'(c); req_lock = LW'(l); req_op = op;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        check_out(tag, eg, ec, l, ee, ed);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < NL; i++) begin m_held[i] = 0; m_owner[i] = 0; m_cnt[i] = 0; end
        for (int i = 0; i < NC; i++) m_wait[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check_out("R1", 0, 0, 0, 0, 0);            // R1 quiet after reset
        issue(0, 0, 0, 0);
        issue(1, 3, 0, 0);                         // R2 free lock granted
        issue(1, 5, 0, 0);                         // R3 waiters queue
        issue(1, 7, 0, 0);
        issue(1, 9, 0, 0);
        issue(1, 4, 0, 1);                         // R6 non-holder release
        issue(1, 2, 5, 1);                         // R6 release of FREE lock
        issue(1, 3, 0, 0);                         // R7 holder re-acquires
        issue(1, 8, 1, 0);                         // R8 other lock independent
        issue(1, 3, 0, 1);                         // R4 handoff to 5
        issue(1, 5, 0, 1);                         // R4 handoff to 7
        issue(1, 7, 0, 1);                         // R4 handoff to 9
        issue(1, 9, 0, 1);                         // R5 lock vacated
        issue(1, 11, 0, 0);                        // R5 re-acquire granted at once
        issue(1, 11, 0, 1);
        issue(1, 8, 1, 1);
        // full wait list: core 0 holds lock 2, all others queue in order
        issue(1, 0, 2, 0);
        for (int c = 1; c < NC; c++) issue(1, c, 2, 0);
        for (int c = 0; c < NC; c++) issue(1, c, 2, 1);
        // seeded random traffic; R8 covered by interleaved locks
        for (int n = 0; n < 4000; n++) begin
            int l, c;
            bit op, v;
            l  = int'($urandom_range(0, 2));
            c  = int'($urandom_range(0, NC - 1));
            if (m_held[l] && $urandom_range(0, 2) == 0) c = m_owner[l];
            op = ($urandom_range(0, 1) == 1);
            v  = ($urandom_range(0, 7) != 0) && !m_wait[c];
            issue(v, c, l, op);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule